// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a new setting into an external clock synthesizer that takes its configuration through a one-bit serial port. A start pulse samples four parameters: the feedback divider, the reference divider, a VCO range select and a post-divider. If any of them is out of range, the block raises an error flag and the synthesizer is left alone. If they are all legal, the block builds a 27-bit programming word and gates the synthesizer output off. It then shifts the word out one bit per strobe. After the final strobe it turns the output back on.

Each bit goes out as a data level followed by a strobe pulse. The level is placed on the data line one cycle before the strobe rises and is held while the strobe is high, so every bit takes two cycles. While the block is idle, a separate enable command can force the synthesizer output on or off without loading a new word.

Top module: `clksynth_loader`

## Requirements
- R1: After reset, out_en, busy, done, err and ser_strobe are all 0.
- R2: A start while idle with a parameter out of range sets err on the next cycle. Out of range means n_div or m_div outside 3..127, vco_sel other than 1 or 8, or post_div other than 1, 2, 4 or 8. No strobe is issued, busy stays 0 and out_en keeps its value.
- R3: A start while idle with all parameters legal clears err. On the next cycle busy is 1 and out_en is 0, and out_en stays 0 for as long as busy is 1.
- R4: Shifted bits 0..6 are n_div and bits 7..13 are m_div, each sent least significant bit first.
- R5: Shifted bit 14 is 1 only when vco_sel is 0, so it is 0 for every legal select. Bits 15 and 16 are both 1.
- R6: Shifted bit 17 is 1 when post_div is 2 or 8. Bit 18 is 1 when post_div is 4 or 8.
- R7: Shifted bits 19..26 are 1, 0, 1, 0, 1, 0, 0, 0 in that order.
- R8: A transfer issues exactly 27 strobe pulses. ser_data is driven one cycle before each strobe rises and does not change while the strobe is high.
- R9: On the cycle after the last strobe, busy falls, out_en rises and done is 1 for exactly one cycle.
- R10: While idle, en_cmd sets out_en to en_val on the next cycle. While busy, en_cmd is ignored.
- R11: A start while busy is ignored, and the word in flight is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to validate and load the parameters |
| n_div | input | 7 | Feedback divider |
| m_div | input | 7 | Reference divider |
| vco_sel | input | 4 | VCO range select (1 or 8) |
| post_div | input | 4 | Output post-divider (1, 2, 4 or 8) |
| en_cmd | input | 1 | Direct enable command |
| en_val | input | 1 | Level applied by en_cmd |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_strobe | output | 1 | Per-bit load strobe |
| out_en | output | 1 | Synthesizer output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the output is re-enabled |
| err | output | 1 | Last start was rejected |

## Verification
A wrong bit counter changes the number of strobes. A shifter that is off by one places a divider bit in the wrong slot. Either fault shows up as a mismatch between the captured 27-bit word and the expected word when done pulses, at most 55 cycles after start. A phase register that is out of step lets ser_data move while the strobe is high, which is visible on the very strobe where it happens. Faults in the enable gating or the range check show up on out_en or err one cycle after the stimulus that should have moved them.

// File: rtl/clksynth_loader.sv
module clksynth_loader #(
  parameter int DIV_W   = 7,
  parameter int SEL_W   = 4,
  parameter int DIV_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] n_div,
  input  logic [DIV_W-1:0] m_div,
  input  logic [SEL_W-1:0] vco_sel,
  input  logic [SEL_W-1:0] post_div,
  input  logic             en_cmd,
  input  logic             en_val,
  output logic             ser_data,
  output logic             ser_strobe,
  output logic             out_en,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int WORD_W  = 2*DIV_W + 13;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int DIV_MAX = (1 << DIV_W) - 1;

  logic [WORD_W-1:0] word, sh;
  logic [CNT_W-1:0]  cnt;
  logic              phase;
  logic              n_ok, m_ok, v_ok, r_ok, legal;
  logic              r_two, r_four;

  assign n_ok   = (int'(n_div) >= DIV_MIN) && (int'(n_div) <= DIV_MAX);
  assign m_ok   = (int'(m_div) >= DIV_MIN) && (int'(m_div) <= DIV_MAX);
  assign v_ok   = (vco_sel == SEL_W'(1)) || (vco_sel == SEL_W'(8));
  assign r_ok   = (post_div == SEL_W'(1)) || (post_div == SEL_W'(2)) ||
                  (post_div == SEL_W'(4)) || (post_div == SEL_W'(8));
  assign legal  = n_ok && m_ok && v_ok && r_ok;
  assign r_two  = (post_div == SEL_W'(2)) || (post_div == SEL_W'(8));
  assign r_four = (post_div == SEL_W'(4)) || (post_div == SEL_W'(8));

  assign word = {8'b0001_0101, r_four, r_two, 2'b11, (vco_sel == '0), m_div, n_div};

  assign ser_strobe = busy && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      phase    <= 1'b0;
      ser_data <= 1'b0;
      out_en   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          err <= !legal;
          if (legal) begin
            sh       <= word;
            ser_data <= word[0];
            cnt      <= '0;
            phase    <= 1'b0;
            busy     <= 1'b1;
            out_en   <= 1'b0;
          end
        end else if (en_cmd) begin
          out_en <= en_val;
        end
      end else if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (cnt == CNT_W'(WORD_W-1)) begin
          busy     <= 1'b0;
          out_en   <= 1'b1;
          done     <= 1'b1;
          ser_data <= 1'b0;
        end else begin
          cnt      <= cnt + 1'b1;
          sh       <= sh >> 1;
          ser_data <= sh[1];
        end
      end
    end
  end
endmodule

// File: rtl/clksynth_loader_chk.sv
module clksynth_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ser_data,
  input logic ser_strobe,
  input logic out_en,
  input logic busy,
  input logic done,
  input logic err
);
  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_en);
  assert_strobe_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |-> busy);
  assert_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_strobe) |-> $stable(ser_data));
  assert_done_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && out_en));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reject_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !$past(busy)) |-> !busy);
endmodule

bind clksynth_loader clksynth_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ser_data(ser_data),
  .ser_strobe(ser_strobe), .out_en(out_en), .busy(busy), .done(done), .err(err)
);

// File: tb/tb_clksynth_loader.sv
module tb_clksynth_loader;
  logic clk = 0, rst_n = 0, start = 0, en_cmd = 0, en_val = 0;
  logic [6:0] n_div = 0, m_div = 0;
  logic [3:0] vco_sel = 0, post_div = 0;
  logic ser_data, ser_strobe, out_en, busy, done, err;
  int checks = 0, fails = 0;
  bit wd_hit = 0;

  always #4 clk = ~clk;

  clksynth_loader dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit legal_f(int n, int m, int v, int r);
    return n >= 3 && n <= 127 && m >= 3 && m <= 127 && (v == 1 || v == 8) &&
           (r == 1 || r == 2 || r == 4 || r == 8);
  endfunction

  function automatic logic [26:0] exp_word(int n, int m, int v, int r);
    logic [26:0] w;
    for (int i = 0; i < 7; i++) begin
      w[i]   = n[i];
      w[7+i] = m[i];
    end
    w[14] = (v == 0);
    w[15] = 1; w[16] = 1;
    w[17] = (r == 2 || r == 8);
    w[18] = (r == 4 || r == 8);
    w[19] = 1; w[20] = 0; w[21] = 1; w[22] = 0;
    w[23] = 1; w[24] = 0; w[25] = 0; w[26] = 0;
    return w;
  endfunction

  task automatic run(input int n, input int m, input int v, input int r, input bit poke);
    logic [26:0] got = '0, expw;
    int nstrobe = 0, cyc = 0;
    logic prev_d, prev_s = 0;
    bit ok_gate = 1, ok_setup = 1, seen_done = 0;
    bit prev_oe = out_en;
    @(negedge clk);
    n_div = 7'(n); m_div = 7'(m); vco_sel = 4'(v); post_div = 4'(r); start = 1;
    @(negedge clk);
    start = 0;
    if (!legal_f(n, m, v, r)) begin
      chk(err === 1'b1 && busy === 1'b0, "R2 err", err, 1);
      for (int k = 0; k < 6; k++) begin
        if (ser_strobe || out_en !== prev_oe) ok_gate = 0;
        @(negedge clk);
      end
      chk(ok_gate, "R2 no shift, out_en held", out_en, prev_oe);
      return;
    end
    chk(err === 1'b0 && busy === 1'b1 && out_en === 1'b0, "R3 start", {err, busy, out_en}, 3'b010);
    expw = exp_word(n, m, v, r);
    prev_d = ser_data;
    while (!seen_done && cyc < 200) begin
      if (busy && out_en) ok_gate = 0;
      if (ser_strobe) begin
        if (!prev_s && ser_data !== prev_d) ok_setup = 0;
        if (!prev_s) begin
          if (nstrobe < 27) got[nstrobe] = ser_data;
          nstrobe++;
        end
      end
      if (done) seen_done = 1;
      prev_d = ser_data; prev_s = ser_strobe;
      if (poke && cyc == 10) begin
        n_div = 7'd99; m_div = 7'd50; post_div = 4'd8; start = 1;
      end
      if (poke && cyc == 11) start = 0;
      if (poke && cyc == 20) begin en_cmd = 1; en_val = 1; end
      if (poke && cyc == 21) en_cmd = 0;
      if (!seen_done) @(negedge clk);
      cyc++;
    end
    chk(ok_gate, "R3 gate low in xfer", 0, 1);
    chk(ok_setup, "R8 setup", 0, 1);
    chk(nstrobe == 27, "R8 strobes", nstrobe, 27);
    chk(got[13:0] == expw[13:0], "R4 dividers", got[13:0], expw[13:0]);
    chk(got[16:14] == expw[16:14], "R5 vco/fixed", got[16:14], expw[16:14]);
    chk(got[18:17] == expw[18:17], "R6 post-div", got[18:17], expw[18:17]);
    chk(got[26:19] == expw[26:19], "R7 tail", got[26:19], expw[26:19]);
    if (poke) chk(got == expw, "R11 start ignored", got, expw);
    chk(seen_done && out_en === 1'b1 && busy === 1'b0, "R9 restore", {out_en, busy}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0, "R9 done width", done, 0);
  endtask

  initial begin
    #200000;
    wd_hit = 1;
  end

  initial begin
    int n, m, v, r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(out_en === 0 && busy === 0 && done === 0 && err === 0 && ser_strobe === 0,
        "R1 reset", {out_en, busy, done, err, ser_strobe}, 0);
    rst_n = 1;
    @(negedge clk);
    en_cmd = 1; en_val = 1; @(negedge clk); en_cmd = 0;
    chk(out_en === 1'b1, "R10 force on", out_en, 1);
    en_cmd = 1; en_val = 0; @(negedge clk); en_cmd = 0;
    chk(out_en === 1'b0, "R10 force off", out_en, 0);
    run(3, 127, 1, 1, 0);
    run(127, 3, 8, 8, 1);
    run(2, 50, 1, 2, 0);
    run(50, 128 - 128, 1, 4, 0);
    run(10, 10, 0, 1, 0);
    run(10, 10, 8, 3, 0);
    for (int i = 0; i < 40 && !wd_hit; i++) begin
      n = $urandom_range(0, 127);
      m = $urandom_range(0, 127);
      case ($urandom_range(0, 3))
        0: v = $urandom_range(0, 15);
        1: v = 1;
        default: v = 8;
      endcase
      case ($urandom_range(0, 4))
        0: r = $urandom_range(0, 15);
        1: r = 1;
        2: r = 2;
        3: r = 4;
        default: r = 8;
      endcase
      if ($urandom_range(0, 3) != 0) begin
        if (n < 3) n = n + 3;
        if (m < 3) m = m + 3;
      end
      run(n, m, v, r, ($urandom_range(0, 3) == 0));
    end
    if (wd_hit) chk(0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (wd_hit);
    #100;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule